// File: doc/BRIEF.md
# Column-Serial AES-128 Encryption Core

This core encrypts 128-bit blocks under AES-128, producing one 32-bit column of a round result per clock cycle. Each column is formed by four byte-addressed lookups into combined substitution/mixing tables, XORed together and with one word of the round key. The tables sit behind a registered read, so a column takes two cycles from address to result. Two independent blocks share the datapath on alternating cycles: while one block's column is in the table read, the other block's next column is being addressed. The read latency is therefore hidden and no column ever needs a result that is still in flight.

A block is offered with a valid/ready handshake and carries a small tag. The core does not expand keys. Instead it publishes the index of the round key it needs, and the surrounding logic returns that 128-bit key in the same cycle. Every block goes through a key-whitening pass first. Nine full rounds follow, then a final round that uses plain substituted bytes with the row rotation and no column mixing. The ciphertext leaves with its tag on a one-cycle done strobe.

Top module: `aes_col_enc`

## Requirements
- R1: After a synchronous reset, `in_ready` is 1 and `out_valid` is 0, and `out_valid` stays 0 until a block has been accepted.
- R2: `out_block` is the AES-128 encryption of the accepted `in_block` under the keys supplied on `rk_word`. Byte 0 of the block is bits [127:120], and state column j is bits [127-32j -: 32] with its row 0 in the top byte. The key 2b7e151628aed2a6abf7158809cf4f3c turns 3243f6a8885a308d313198a2e0370734 into 3925841d02dc09fbdc118597196a0b32.
- R3: `rk_round` only takes values from 0 to 10. The core uses `rk_word` in the same cycle it drives `rk_round`, taking column j of the key from bits [127-32j -: 32].
- R4: At most two blocks are in flight. A block is accepted at a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 exactly while two blocks are in flight, so a third block waits until one of them finishes.
- R5: `out_tag` equals the `in_tag` that was accepted together with that block.
- R6: Each accepted block produces exactly one `out_valid` cycle, and results leave in the order their blocks were accepted.
- R7: `out_valid` for a block rises 88 or 89 clock edges after the edge that accepted it. Which of the two applies depends on which interleave slot's turn comes first.
- R8: In any cycle where `out_valid` is 1, `in_ready` is also 1, because the finished block has freed its slot.
- R9: Two blocks accepted on consecutive edges progress in alternate cycles, and their results appear between 1 and 3 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Plaintext block offered |
| in_ready | output | 1 | A slot is free to take a block |
| in_tag | input | TAG_W | Tag carried with the block |
| in_block | input | 128 | Plaintext block |
| rk_round | output | 4 | Index of the round key needed this cycle |
| rk_word | input | 128 | Round key for `rk_round`, combinational |
| out_valid | output | 1 | One-cycle strobe: ciphertext ready |
| out_tag | output | TAG_W | Tag of the finished block |
| out_block | output | 128 | Ciphertext |

## Verification
The assertions assume that `rk_word` always holds the schedule entry that `rk_round` names, and that the key schedule stays fixed while any block is in flight. The bench computes the full schedule for one key in advance and drives `rk_word` from that table, indexed by `rk_round`. It changes the key only after its scoreboard has drained, so no block ever sees two keys. The assertions also assume that `in_block` and `in_tag` are stable only at the accepting edge. The bench drives them at falling edges and holds them until that edge has passed.

// File: rtl/aes_col_pkg.sv
package aes_col_pkg;

    localparam int COL_W      = 32;
    localparam int BLK_W      = 128;
    localparam int NCOL       = BLK_W / COL_W;
    localparam int AES_ROUNDS = 10;
    localparam int RND_W      = $clog2(AES_ROUNDS + 2);
    localparam int CIDX_W     = $clog2(NCOL);

    typedef logic [7:0]       byte_t;
    typedef logic [COL_W-1:0] col_t;

    // what the combine stage does with a column
    typedef enum logic [1:0] {
        RK_WHITEN,
        RK_MIDDLE,
        RK_LAST
    } rkind_e;

    // one column travelling through the table stage
    typedef struct packed {
        logic              vld;
        logic [RND_W-1:0]  rnd;
        logic [CIDX_W-1:0] col;
        col_t              raw;
    } lane_t;

    function automatic byte_t gf_x2(byte_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic byte_t gf_mul(byte_t a, byte_t b);
        byte_t p;
        byte_t x;
        p = 8'h00;
        x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p = p ^ x;
            x = gf_x2(x);
        end
        return p;
    endfunction

    // multiplicative inverse as a^254, zero maps to zero
    function automatic byte_t gf_inv(byte_t a);
        byte_t r;
        byte_t sq;
        r  = 8'h01;
        sq = a;
        for (int i = 1; i < 8; i++) begin
            sq = gf_mul(sq, sq);
            r  = gf_mul(r, sq);
        end
        return r;
    endfunction

    function automatic byte_t rotl8(byte_t b, int n);
        return byte_t'((b << n) | (b >> (8 - n)));
    endfunction

    function automatic byte_t subst(byte_t a);
        byte_t b;
        b = gf_inv(a);
        return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
    endfunction

    // combined substitution and mixing word, rotated right by rot bytes
    function automatic col_t tab_word(byte_t a, int rot);
        byte_t s;
        col_t  w;
        s = subst(a);
        w = {gf_x2(s), s, s, gf_x2(s) ^ s};
        return col_t'((w >> (8 * rot)) | (w << (COL_W - 8 * rot)));
    endfunction

    // position of the plain substituted byte inside a rotated table word
    function automatic int plain_lsb(int rot);
        return 8 * (3 - ((1 + rot) % 4));
    endfunction

endpackage

// File: rtl/aes_col_trom.sv
module aes_col_trom
    import aes_col_pkg::*;
#(
    parameter int ROT = 0
) (
    input  logic       clk,
    input  logic [7:0] addr,
    output col_t       q
);

    localparam int DEPTH = 256;

    col_t mem [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem[i] = tab_word(byte_t'(i), ROT);
        end
    end

    always_ff @(posedge clk) begin
        q <= mem[addr];
    end

endmodule

// File: rtl/aes_col_sched.sv
module aes_col_sched
    import aes_col_pkg::*;
#(
    parameter int NSLOT = 2,
    parameter int TAG_W = 1,
    localparam int SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic              fin_vld,
    input  logic [SW-1:0]     fin_slot,
    output logic              in_ready,
    output logic              acc,
    output logic [SW-1:0]     acc_slot,
    output logic              iss_vld,
    output logic [SW-1:0]     iss_slot,
    output logic [RND_W-1:0]  iss_rnd,
    output logic [CIDX_W-1:0] iss_col,
    output logic [NSLOT-1:0]  busy,
    output logic [TAG_W-1:0]  fin_tag
);

    logic [SW-1:0]     ph;
    logic [RND_W-1:0]  rnd [NSLOT];
    logic [CIDX_W-1:0] col [NSLOT];
    logic [TAG_W-1:0]  tag [NSLOT];
    logic              found;

    assign in_ready = !(&busy);
    assign acc      = in_valid && in_ready;
    assign iss_slot = ph;
    assign iss_rnd  = rnd[ph];
    assign iss_col  = col[ph];
    assign iss_vld  = busy[ph] && (rnd[ph] <= RND_W'(AES_ROUNDS));
    assign fin_tag  = tag[fin_slot];

    always_comb begin
        acc_slot = '0;
        found    = 1'b0;
        for (int s = 0; s < NSLOT; s++) begin
            if (!busy[s] && !found) begin
                acc_slot = SW'(s);
                found    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph   <= '0;
            busy <= '0;
            for (int s = 0; s < NSLOT; s++) begin
                rnd[s] <= '0;
                col[s] <= '0;
                tag[s] <= '0;
            end
        end else begin
            ph <= (ph == SW'(NSLOT - 1)) ? '0 : ph + 1'b1;
            if (iss_vld) begin
                col[ph] <= col[ph] + 1'b1;
                if (col[ph] == CIDX_W'(NCOL - 1)) rnd[ph] <= rnd[ph] + 1'b1;
            end
            if (fin_vld) busy[fin_slot] <= 1'b0;
            if (acc) begin
                busy[acc_slot] <= 1'b1;
                rnd[acc_slot]  <= '0;
                col[acc_slot]  <= '0;
                tag[acc_slot]  <= in_tag;
            end
        end
    end

    // R4
    accept_count_chk: assert property (@(posedge clk) disable iff (rst)
        acc |=> ($countones(busy) == $past($countones(busy)) + 1 - int'($past(fin_vld))));

endmodule

// File: rtl/aes_col_round.sv
module aes_col_round
    import aes_col_pkg::*;
(
    input  rkind_e                    kind,
    input  col_t                      raw,
    input  logic [NCOL-1:0][COL_W-1:0] tq,
    input  col_t                      rk_col,
    output col_t                      res
);

    col_t mix;
    col_t last;

    always_comb begin
        mix = '0;
        for (int k = 0; k < NCOL; k++) mix = mix ^ tq[k];
    end

    for (genvar k = 0; k < NCOL; k++) begin : g_last
        localparam int LSB = plain_lsb(k);
        assign last[COL_W-1-8*k -: 8] = tq[k][LSB +: 8];
    end

    always_comb begin
        case (kind)
            RK_WHITEN: res = raw ^ rk_col;
            RK_LAST:   res = last ^ rk_col;
            default:   res = mix ^ rk_col;
        endcase
    end

endmodule

// File: rtl/aes_col_enc.sv
module aes_col_enc
    import aes_col_pkg::*;
#(
    parameter int NSLOT = 2,
    parameter int TAG_W = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [TAG_W-1:0] in_tag,
    input  logic [BLK_W-1:0] in_block,
    output logic [RND_W-1:0] rk_round,
    input  logic [BLK_W-1:0] rk_word,
    output logic             out_valid,
    output logic [TAG_W-1:0] out_tag,
    output logic [BLK_W-1:0] out_block
);

    localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1;

    logic              acc, iss_vld, fin_vld;
    logic [SW-1:0]     acc_slot, iss_slot, s1_slot;
    logic [RND_W-1:0]  iss_rnd;
    logic [CIDX_W-1:0] iss_col;
    logic [NSLOT-1:0]  busy;
    logic [TAG_W-1:0]  fin_tag;

    col_t  cur [NSLOT][NCOL];
    col_t  nxt [NSLOT][NCOL-1];
    lane_t s1;
    col_t  rk_col, res;
    rkind_e kind;

    logic [NCOL-1:0][7:0]       taddr;
    logic [NCOL-1:0][COL_W-1:0] tq;

    aes_col_sched #(.NSLOT(NSLOT), .TAG_W(TAG_W)) u_sched (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_tag   (in_tag),
        .fin_vld  (fin_vld),
        .fin_slot (s1_slot),
        .in_ready (in_ready),
        .acc      (acc),
        .acc_slot (acc_slot),
        .iss_vld  (iss_vld),
        .iss_slot (iss_slot),
        .iss_rnd  (iss_rnd),
        .iss_col  (iss_col),
        .busy     (busy),
        .fin_tag  (fin_tag)
    );

    // four rotated lookups, each addressed from a shifted column
    for (genvar k = 0; k < NCOL; k++) begin : g_tab
        logic [CIDX_W-1:0] cidx;
        col_t              src;
        assign cidx     = iss_col + CIDX_W'(k);
        assign src      = cur[iss_slot][cidx];
        assign taddr[k] = src[COL_W-1-8*k -: 8];
        aes_col_trom #(.ROT(k)) u_rom (
            .clk  (clk),
            .addr (taddr[k]),
            .q    (tq[k])
        );
    end

    // lane register runs alongside the table read
    always_ff @(posedge clk) begin
        if (rst) begin
            s1      <= '0;
            s1_slot <= '0;
        end else begin
            s1.vld  <= iss_vld;
            s1.rnd  <= iss_rnd;
            s1.col  <= iss_col;
            s1.raw  <= cur[iss_slot][iss_col];
            s1_slot <= iss_slot;
        end
    end

    assign rk_round = s1.vld ? s1.rnd : '0;
    assign rk_col   = rk_word[BLK_W-1-COL_W*s1.col -: COL_W];
    assign kind     = (s1.rnd == '0) ? RK_WHITEN :
                      (s1.rnd == RND_W'(AES_ROUNDS)) ? RK_LAST : RK_MIDDLE;
    assign fin_vld  = s1.vld && (s1.col == CIDX_W'(NCOL - 1)) &&
                      (s1.rnd == RND_W'(AES_ROUNDS));

    aes_col_round u_round (
        .kind   (kind),
        .raw    (s1.raw),
        .tq     (tq),
        .rk_col (rk_col),
        .res    (res)
    );

    // state write-back and block load
    always_ff @(posedge clk) begin
        if (s1.vld) begin
            if (s1.col != CIDX_W'(NCOL - 1)) begin
                nxt[s1_slot][s1.col] <= res;
            end else begin
                for (int j = 0; j < NCOL - 1; j++) cur[s1_slot][j] <= nxt[s1_slot][j];
                cur[s1_slot][NCOL-1] <= res;
            end
        end
        if (acc) begin
            for (int j = 0; j < NCOL; j++) begin
                cur[acc_slot][j] <= in_block[BLK_W-1-COL_W*j -: COL_W];
            end
        end
        if (fin_vld) begin
            for (int j = 0; j < NCOL - 1; j++) begin
                out_block[BLK_W-1-COL_W*j -: COL_W] <= nxt[s1_slot][j];
            end
            out_block[COL_W-1:0] <= res;
            out_tag <= fin_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= fin_vld;
    end

    // R9
    slot_clash_chk: assert property (@(posedge clk) disable iff (rst)
        (iss_vld && s1.vld) |-> (iss_slot != s1_slot));

    // R3
    rk_round_range_chk: assert property (@(posedge clk) disable iff (rst)
        s1.vld |-> (rk_round <= RND_W'(AES_ROUNDS)));

    // R8
    done_frees_slot_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !(&busy));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (busy == '0 && !$past(fin_vld)) |-> !out_valid);

endmodule

// File: tb/tb_aes_col_enc.sv
module tb_aes_col_enc;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         in_ready;
    logic [0:0]   in_tag;
    logic [127:0] in_block;
    logic [3:0]   rk_round;
    logic [127:0] rk_word;
    logic         out_valid;
    logic [0:0]   out_tag;
    logic [127:0] out_block;

    typedef struct {
        logic [127:0] ct;
        logic         tag;
        int           edge_no;
    } exp_t;

    exp_t         sbq [$];
    int           out_times [$];
    logic [127:0] rks [11];
    logic [7:0]   sb [256];
    int           cyc = 0;
    int           total = 0;
    int           bad = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign rk_word = (rk_round <= 4'd10) ? rks[rk_round] : '0;

    aes_col_enc dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_tag(in_tag), .in_block(in_block), .rk_round(rk_round),
        .rk_word(rk_word), .out_valid(out_valid), .out_tag(out_tag),
        .out_block(out_block)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] m2(logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] mul(logic [7:0] a, logic [7:0] b);
        logic [7:0] p;
        logic [7:0] x;
        p = 0;
        x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p = p ^ x;
            x = m2(x);
        end
        return p;
    endfunction

    task automatic build_sbox();
        for (int a = 0; a < 256; a++) begin
            logic [7:0] inv;
            logic [7:0] b;
            inv = 8'h00;
            for (int y = 1; y < 256; y++) if (mul(8'(a), 8'(y)) == 8'h01) inv = 8'(y);
            b = inv;
            sb[a] = b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]} ^
                    {b[3:0], b[7:4]} ^ 8'h63;
        end
    endtask

    task automatic set_key(input logic [127:0] k);
        logic [31:0] w [44];
        logic [31:0] t;
        logic [7:0]  rc;
        rc = 8'h01;
        for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
        for (int i = 4; i < 44; i++) begin
            t = w[i-1];
            if (i % 4 == 0) begin
                t = {t[23:0], t[31:24]};
                t = {sb[t[31:24]], sb[t[23:16]], sb[t[15:8]], sb[t[7:0]]} ^ {rc, 24'h0};
                rc = m2(rc);
            end
            w[i] = w[i-4] ^ t;
        end
        for (int r = 0; r < 11; r++) rks[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
    endtask

    function automatic logic [127:0] ref_enc(input logic [127:0] pt);
        logic [7:0]   s [16];
        logic [7:0]   t [16];
        logic [127:0] blk;
        logic [7:0]   a0, a1, a2, a3;
        blk = pt ^ rks[0];
        for (int r = 1; r <= 10; r++) begin
            for (int i = 0; i < 16; i++) s[i] = sb[blk[127-8*i -: 8]];
            for (int c = 0; c < 4; c++)
                for (int w = 0; w < 4; w++) t[4*c+w] = s[4*((c+w)%4)+w];
            if (r < 10) begin
                for (int c = 0; c < 4; c++) begin
                    a0 = t[4*c]; a1 = t[4*c+1]; a2 = t[4*c+2]; a3 = t[4*c+3];
                    t[4*c]   = m2(a0) ^ m2(a1) ^ a1 ^ a2 ^ a3;
                    t[4*c+1] = a0 ^ m2(a1) ^ m2(a2) ^ a2 ^ a3;
                    t[4*c+2] = a0 ^ a1 ^ m2(a2) ^ m2(a3) ^ a3;
                    t[4*c+3] = m2(a0) ^ a0 ^ a1 ^ a2 ^ m2(a3);
                end
            end
            for (int i = 0; i < 16; i++) blk[127-8*i -: 8] = t[i];
            blk = blk ^ rks[r];
        end
        return blk;
    endfunction

    // driver: called at a falling edge, returns at a falling edge
    task automatic send(input logic [127:0] pt, input logic tg, output int acc_edge);
        exp_t e;
        in_valid = 1'b1;
        in_block = pt;
        in_tag   = tg;
        while (!in_ready) @(negedge clk);
        acc_edge  = cyc + 1;
        e.ct      = ref_enc(pt);
        e.tag     = tg;
        e.edge_no = acc_edge;
        sbq.push_back(e);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        while (sbq.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // monitor: pops the scoreboard as results appear
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sbq.size() == 0) begin
                chk(1'b0, "R6 unexpected output", out_block, '0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                chk(out_block == e.ct, "R2/R6 ciphertext", out_block, e.ct);
                chk(out_tag[0] == e.tag, "R5 tag", 128'(out_tag), 128'(e.tag));
                chk((cyc - e.edge_no) == 88 || (cyc - e.edge_no) == 89, "R7 latency",
                    128'(cyc - e.edge_no), 128'(88));
                chk(in_ready == 1'b1, "R8 slot free on done", 128'(in_ready), 128'(1));
                out_times.push_back(cyc);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=%0d exp=finished", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int ea, eb, ec, n0;
        logic [127:0] pt;
        rst      = 1'b1;
        in_valid = 1'b0;
        in_tag   = '0;
        in_block = '0;
        build_sbox();
        set_key(128'h2b7e151628aed2a6abf7158809cf4f3c);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: idle after reset
        chk(in_ready == 1'b1, "R1 ready after reset", 128'(in_ready), 128'(1));
        chk(out_valid == 1'b0, "R1 no output after reset", 128'(out_valid), 128'(0));
        repeat (5) @(negedge clk);
        chk(out_valid == 1'b0, "R1 quiet while idle", 128'(out_valid), 128'(0));

        // R2: known answer, key 2b7e...
        send(128'h3243f6a8885a308d313198a2e0370734, 1'b1, ea);
        chk(ref_enc(128'h3243f6a8885a308d313198a2e0370734) ==
            128'h3925841d02dc09fbdc118597196a0b32, "R2 model vector",
            ref_enc(128'h3243f6a8885a308d313198a2e0370734),
            128'h3925841d02dc09fbdc118597196a0b32);
        drain();

        // R2: second known answer with another key
        set_key(128'h000102030405060708090a0b0c0d0e0f);
        send(128'h00112233445566778899aabbccddeeff, 1'b0, ea);
        drain();

        // R4, R9: two blocks back to back, then a third that has to wait
        out_times.delete();
        send(128'h0123456789abcdeffedcba9876543210, 1'b0, ea);
        send(128'hffffffffffffffffffffffffffffffff, 1'b1, eb);
        chk(in_ready == 1'b0, "R4 full after two blocks", 128'(in_ready), 128'(0));
        send(128'h00000000000000000000000000000000, 1'b0, ec);
        chk((ec - eb) > 80, "R4 third block held back", 128'(ec - eb), 128'(81));
        drain();
        chk(out_times.size() == 3, "R6 one result each", 128'(out_times.size()), 128'(3));
        if (out_times.size() >= 2)
            chk((out_times[1] - out_times[0]) >= 1 && (out_times[1] - out_times[0]) <= 3,
                "R9 interleaved finish", 128'(out_times[1] - out_times[0]), 128'(1));

        // R2, R5, R6: random stream with gaps and tags under a third key
        set_key({$urandom, $urandom, $urandom, $urandom});
        n0 = total;
        for (int i = 0; i < 10; i++) begin
            pt = {$urandom, $urandom, $urandom, $urandom};
            send(pt, 1'($urandom), ea);
            repeat ($urandom % 4) @(negedge clk);
        end
        drain();
        chk(total - n0 == 40, "R6 all random results seen", 128'(total - n0), 128'(40));
        chk(sbq.size() == 0, "R6 scoreboard empty", 128'(sbq.size()), 128'(0));
        chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 idle again",
            128'({in_ready, out_valid}), 128'(2'b10));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule